// File: doc/BRIEF.md
# Calendar Counter with Programmable Leap Year

This block keeps the time of day and the calendar date for a real-time clock. A prescaler divides the oscillator clock down to one tick per second. The tick advances a chain of counters: seconds, minutes, hours, day of month and month. At each year end it also advances a two-bit leap-phase counter. The chain keeps no year value. February has a 29th day only when the leap phase is zero, so the host chooses which years are leap years by presetting that phase.

A small mode register selects the oscillator frequency code, the 12-hour or 24-hour format and the run state. The run bit cannot be set until the oscillator has been reported good. An oscillator failure clears it again. The host loads any counter field directly through a simple write port. The new value appears on the next cycle and does not ripple into the higher fields.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the outputs read as follows: seconds 0, minutes 0, hours 0, pm 0, day 1, month 1, leap_phase 0, run 0 and tick 0. The hour format after reset is 24-hour and the frequency code is 0.
- R2: While run is 1, tick is high for exactly one cycle in every F cycles. F is the parameter F_XT0, F_XT1, F_XT2 or F_XT3, chosen by mode bits wr_data[7:6] = 0, 1, 2 or 3. Tick is never high while run is 0.
- R3: Writing run (mode bit wr_data[3]) as 0 freezes every counter and clears the prescaler. Writing run as 1 again gives the first tick F−1 cycles after the write cycle's closing edge.
- R4: A write of run = 1 is ignored unless osc_ok has been seen high in an earlier cycle since the last osc_fail. An osc_fail pulse forces run to 0 on the next edge.
- R5: Seconds count 0 to 59. On the tick at 59, seconds wrap to 0 and minutes advance. Minutes wrap the same way from 59 to 0.
- R6: With mode bit wr_data[2] = 0 (24-hour), hours count 0 to 23. Leaving 23:59:59 gives 00:00:00 and advances the day.
- R7: With mode bit wr_data[2] = 1 (12-hour), hours run 12, 1, 2 … 11. The pm flag toggles when 11 becomes 12. The day advances only when 11:59:59 with pm = 1 rolls over.
- R8: Months 1 to 12 last 31, 28/29, 31, 30, 31, 30, 31, 31, 30, 31, 30 and 31 days. Leaving the last day gives day 1 of the next month. December is followed by month 1.
- R9: Day 29 of February follows day 28 only when leap_phase is 0. Otherwise February 28 is followed by March 1.
- R10: leap_phase advances by one, wrapping 3 to 0, when December 31 rolls over. The host presets it with a write to select 6 (data bits [1:0]).
- R11: A counter write takes effect at the next edge and produces no carry. The selects are 1 seconds, 2 minutes, 3 hours, 4 day and 5 month. In 12-hour mode the hours data is the hour in [3:0] and pm in [7]. A write in a tick cycle wins, and the chain does not advance in that cycle. With no write and no tick, every counter holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_ok | input | 1 | Oscillator declared running correctly |
| osc_fail | input | 1 | Oscillator failure event |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 mode, 1 sec, 2 min, 3 hour, 4 day, 5 month, 6 leap phase |
| wr_data | input | 8 | Write data |
| run | output | 1 | Current run state |
| tick | output | 1 | One-cycle 1 Hz tick |
| seconds | output | 6 | Seconds 0–59 |
| minutes | output | 6 | Minutes 0–59 |
| hours | output | 5 | Hours, 0–23 or 1–12 |
| pm | output | 1 | PM flag in 12-hour mode |
| day | output | 5 | Day of month from 1 |
| month | output | 4 | Month 1–12 |
| leap_phase | output | 2 | Years since the last leap year |

## Verification
A wrong prescaler limit or a prescaler left uncleared shows at once as a tick spacing or restart latency that differs from F. Any faulty wrap value or month-length entry appears on the counter outputs one cycle after the tick that crosses that boundary. The bench therefore presets each field next to its boundary and runs only one or two ticks, so a fault shows within a few prescaler periods. A leap-phase error stays hidden until February 28 is crossed, so the bench presets that date directly with each leap phase.

// File: rtl/rtc_cal_pkg.sv
// Shared constants, write-select codes and the month-length function
// for the calendar counter. Assumes months are numbered 1..12.
package rtc_cal_pkg;

    typedef enum logic [2:0] {
        SEL_MODE  = 3'd0,
        SEL_SEC   = 3'd1,
        SEL_MIN   = 3'd2,
        SEL_HOUR  = 3'd3,
        SEL_DAY   = 3'd4,
        SEL_MONTH = 3'd5,
        SEL_LEAP  = 3'd6,
        SEL_NONE  = 3'd7
    } wr_sel_e;

    localparam int SEC_W   = 6;
    localparam int MIN_W   = 6;
    localparam int HOUR_W  = 5;
    localparam int DAY_W   = 5;
    localparam int MONTH_W = 4;

    localparam int MODE_H12_BIT = 2;
    localparam int MODE_RUN_BIT = 3;
    localparam int MODE_XT_LSB  = 6;

    // Number of days in a month; February depends on the leap phase.
    function automatic logic [DAY_W-1:0] month_len(input logic [MONTH_W-1:0] m,
                                                   input logic [1:0] lp);
        case (m)
            4'd2:                      month_len = (lp == 2'd0) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
            default:                   month_len = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the oscillator clock to a one-cycle tick per second.
// Assumes every ratio parameter is at least 1 and fits in CNT_W bits.
// The count is held at zero whenever run is low.
module rtc_prescaler #(
    parameter int unsigned F_XT0 = 32768,
    parameter int unsigned F_XT1 = 4194304,
    parameter int unsigned F_XT2 = 4915200,
    parameter int unsigned F_XT3 = 32000,
    parameter int          CNT_W = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] xt_code,
    output logic       tick
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // Pick the division ratio from the crystal code.
    always_comb begin
        case (xt_code)
            2'd0:    lim = CNT_W'(F_XT0);
            2'd1:    lim = CNT_W'(F_XT1);
            2'd2:    lim = CNT_W'(F_XT2);
            default: lim = CNT_W'(F_XT3);
        endcase
    end

    assign tick = run && (cnt >= lim - 1'b1);

    // Count oscillator cycles; clear when stopped or at the tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (tick)      cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtc_time_chain.sv
// Seconds, minutes and hours counters with 12/24 hour formats.
// Assumes adv is already suppressed in cycles that carry a host write.
// Raises day_carry in the cycle whose edge leaves the last second of a day.
module rtc_time_chain
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              h12,
    input  logic              wr_sec,
    input  logic              wr_min,
    input  logic              wr_hour,
    input  logic [7:0]        wdata,
    output logic [SEC_W-1:0]  sec,
    output logic [MIN_W-1:0]  min,
    output logic [HOUR_W-1:0] hour,
    output logic              pm,
    output logic              day_carry
);
    logic sec_last, min_last, hour_last, hour_step;

    assign sec_last  = (sec >= 6'd59);
    assign min_last  = (min >= 6'd59);
    assign hour_last = h12 ? (hour == 5'd11 && pm) : (hour >= 5'd23);
    assign hour_step = adv && sec_last && min_last;
    assign day_carry = hour_step && hour_last;

    // Seconds counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       sec <= '0;
        else if (wr_sec)  sec <= wdata[SEC_W-1:0];
        else if (adv)     sec <= sec_last ? '0 : sec + 1'b1;
    end

    // Minutes counter, stepped by the seconds wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                min <= '0;
        else if (wr_min)           min <= wdata[MIN_W-1:0];
        else if (adv && sec_last)  min <= min_last ? '0 : min + 1'b1;
    end

    // Hours counter and PM flag in the selected format.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour <= '0;
            pm   <= 1'b0;
        end else if (wr_hour) begin
            hour <= h12 ? {1'b0, wdata[3:0]} : wdata[HOUR_W-1:0];
            pm   <= h12 ? wdata[7] : 1'b0;
        end else if (hour_step) begin
            if (h12) begin
                if (hour == 5'd11) begin
                    hour <= 5'd12;
                    pm   <= ~pm;
                end else if (hour >= 5'd12) begin
                    hour <= 5'd1;
                end else begin
                    hour <= hour + 1'b1;
                end
            end else begin
                hour <= hour_last ? '0 : hour + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_date_chain.sv
// Day-of-month, month and leap-phase counters.
// Assumes adv is the day carry from the time chain. Out-of-range
// written values fall back to day 1 / month 1 on the next carry.
module rtc_date_chain
    import rtc_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic               wr_day,
    input  logic               wr_month,
    input  logic               wr_leap,
    input  logic [7:0]         wdata,
    output logic [DAY_W-1:0]   day,
    output logic [MONTH_W-1:0] month,
    output logic [1:0]         leap
);
    logic day_last, year_last;

    assign day_last  = (day >= month_len(month, leap));
    assign year_last = (month >= 4'd12);

    // Day of month.
    always_ff @(posedge clk) begin
        if (!rst_n)       day <= 5'd1;
        else if (wr_day)  day <= wdata[DAY_W-1:0];
        else if (adv)     day <= day_last ? 5'd1 : day + 1'b1;
    end

    // Month, stepped when the last day of the month rolls over.
    always_ff @(posedge clk) begin
        if (!rst_n)                month <= 4'd1;
        else if (wr_month)         month <= wdata[MONTH_W-1:0];
        else if (adv && day_last)  month <= year_last ? 4'd1 : month + 1'b1;
    end

    // Leap phase, stepped at the end of December 31.
    always_ff @(posedge clk) begin
        if (!rst_n)                            leap <= 2'd0;
        else if (wr_leap)                      leap <= wdata[1:0];
        else if (adv && day_last && year_last) leap <= leap + 1'b1;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
// Top of the calendar counter: mode register, oscillator gating of
// the run bit, write decode, prescaler and the two counter chains.
// Assumes osc_ok and osc_fail are already synchronous to clk.
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int unsigned F_XT0 = 32768,
    parameter int unsigned F_XT1 = 4194304,
    parameter int unsigned F_XT2 = 4915200,
    parameter int unsigned F_XT3 = 32000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               osc_ok,
    input  logic               osc_fail,
    input  logic               wr_en,
    input  logic [2:0]         wr_sel,
    input  logic [7:0]         wr_data,
    output logic               run,
    output logic               tick,
    output logic [SEC_W-1:0]   seconds,
    output logic [MIN_W-1:0]   minutes,
    output logic [HOUR_W-1:0]  hours,
    output logic               pm,
    output logic [DAY_W-1:0]   day,
    output logic [MONTH_W-1:0] month,
    output logic [1:0]         leap_phase
);
    localparam int unsigned F_MAX01 = (F_XT0 > F_XT1) ? F_XT0 : F_XT1;
    localparam int unsigned F_MAX23 = (F_XT2 > F_XT3) ? F_XT2 : F_XT3;
    localparam int unsigned F_MAX   = (F_MAX01 > F_MAX23) ? F_MAX01 : F_MAX23;
    localparam int          CNT_W   = $clog2(F_MAX + 1);

    wr_sel_e    wsel;
    logic       osc_good_q;
    logic       h12_q;
    logic [1:0] xt_q;
    logic       adv, day_carry;

    assign wsel = wr_en ? wr_sel_e'(wr_sel) : SEL_NONE;
    assign adv  = tick && !wr_en;

    // Track whether the oscillator has been declared good since the last failure.
    always_ff @(posedge clk) begin
        if (!rst_n || osc_fail) osc_good_q <= 1'b0;
        else if (osc_ok)        osc_good_q <= 1'b1;
    end

    // Mode register; run is forced low on failure and gated by oscillator health.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run   <= 1'b0;
            h12_q <= 1'b0;
            xt_q  <= 2'd0;
        end else begin
            if (osc_fail)
                run <= 1'b0;
            else if (wsel == SEL_MODE)
                run <= wr_data[MODE_RUN_BIT] && osc_good_q;
            if (wsel == SEL_MODE) begin
                h12_q <= wr_data[MODE_H12_BIT];
                xt_q  <= wr_data[MODE_XT_LSB +: 2];
            end
        end
    end

    rtc_prescaler #(
        .F_XT0 (F_XT0), .F_XT1 (F_XT1), .F_XT2 (F_XT2), .F_XT3 (F_XT3),
        .CNT_W (CNT_W)
    ) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .xt_code (xt_q),
        .tick    (tick)
    );

    rtc_time_chain u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .h12       (h12_q),
        .wr_sec    (wsel == SEL_SEC),
        .wr_min    (wsel == SEL_MIN),
        .wr_hour   (wsel == SEL_HOUR),
        .wdata     (wr_data),
        .sec       (seconds),
        .min       (minutes),
        .hour      (hours),
        .pm        (pm),
        .day_carry (day_carry)
    );

    rtc_date_chain u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (day_carry),
        .wr_day   (wsel == SEL_DAY),
        .wr_month (wsel == SEL_MONTH),
        .wr_leap  (wsel == SEL_LEAP),
        .wdata    (wr_data),
        .day      (day),
        .month    (month),
        .leap     (leap_phase)
    );
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar_core, attached with bind.
// Observes the top ports plus the internal 12-hour mode flag.
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_fail,
    input logic       wr_en,
    input logic       run,
    input logic       tick,
    input logic [5:0] seconds,
    input logic [5:0] minutes,
    input logic [4:0] hours,
    input logic       pm,
    input logic [4:0] day,
    input logic [3:0] month,
    input logic [1:0] leap_phase,
    input logic       h12_q
);
    logic step, day_end;
    assign step    = tick && !wr_en;
    assign day_end = step && seconds == 6'd59 && minutes == 6'd59 &&
                     (h12_q ? (hours == 5'd11 && pm) : (hours == 5'd23));

    // R4
    osc_fail_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        osc_fail |=> !run);

    // R2
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> run);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> ($stable(seconds) && $stable(minutes) && $stable(hours) &&
                               $stable(pm) && $stable(day) && $stable(month) &&
                               $stable(leap_phase)));

    // R5
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && seconds == 6'd59) |=> seconds == 6'd0);

    // R7
    pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && h12_q && hours == 5'd11 && minutes == 6'd59 && seconds == 6'd59)
        |=> pm != $past(pm));

    // R9
    feb_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (day_end && month == 4'd2 && day == 5'd28 && leap_phase != 2'd0)
        |=> (month == 4'd3 && day == 5'd1));

    // R10
    leap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (day_end && month == 4'd12 && day == 5'd31)
        |=> leap_phase == 2'($past(leap_phase) + 2'd1));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_fail   (osc_fail),
    .wr_en      (wr_en),
    .run        (run),
    .tick       (tick),
    .seconds    (seconds),
    .minutes    (minutes),
    .hours      (hours),
    .pm         (pm),
    .day        (day),
    .month      (month),
    .leap_phase (leap_phase),
    .h12_q      (h12_q)
);

// File: tb/sim_rtc_calendar_core.sv
// Directed bench for rtc_calendar_core with small prescaler ratios.
module sim_rtc_calendar_core;
    localparam int CLK_PERIOD = 10;
    localparam int FR0 = 8, FR1 = 12, FR2 = 16, FR3 = 5;
    localparam int WATCHDOG = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_ok = 1'b0, osc_fail = 1'b0, wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic       run, tick, pm;
    logic [5:0] seconds, minutes;
    logic [4:0] hours, day;
    logic [3:0] month;
    logic [1:0] leap_phase;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit cur_h12 = 1'b0;
    logic [1:0] cur_xt = 2'd0;

    rtc_calendar_core #(.F_XT0(FR0), .F_XT1(FR1), .F_XT2(FR2), .F_XT3(FR3)) u0 (
        .clk(clk), .rst_n(rst_n), .osc_ok(osc_ok), .osc_fail(osc_fail),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .run(run), .tick(tick), .seconds(seconds), .minutes(minutes),
        .hours(hours), .pm(pm), .day(day), .month(month), .leap_phase(leap_phase)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected <= %0d", cyc, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic int ratio(input int code);
        case (code)
            0: return FR0;
            1: return FR1;
            2: return FR2;
            default: return FR3;
        endcase
    endfunction

    function automatic int days_of(input int m, input int lp);
        if (m == 2) return (lp == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = 3'(sel); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input bit r, input bit h12, input logic [1:0] xt);
        cur_h12 = h12; cur_xt = xt;
        wr(0, {xt, 2'b00, r, h12, 2'b00});
    endtask

    // Stop, load every field, then start again.
    task automatic load(input int h, input bit p, input int m, input int s,
                        input int d, input int mo, input int lp);
        set_mode(1'b0, cur_h12, cur_xt);
        wr(1, s); wr(2, m);
        wr(3, cur_h12 ? {p, 3'b000, 4'(h)} : h);
        wr(4, d); wr(5, mo); wr(6, lp);
        set_mode(1'b1, cur_h12, cur_xt);
    endtask

    task automatic wait_tick();
        while (!tick) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 seconds", seconds, 0); chk("R1 minutes", minutes, 0);
        chk("R1 hours", hours, 0);     chk("R1 pm", pm, 0);
        chk("R1 day", day, 1);         chk("R1 month", month, 1);
        chk("R1 leap", leap_phase, 0); chk("R1 run", run, 0);
        chk("R1 tick", tick, 0);
    endtask

    task automatic t_osc_gate();
        set_mode(1'b1, 1'b0, 2'd0);
        chk("R4 run blocked before osc_ok", run, 0);
        osc_ok = 1'b1;
        @(negedge clk);
        set_mode(1'b1, 1'b0, 2'd0);
        chk("R4 run accepted after osc_ok", run, 1);
    endtask

    task automatic t_period();
        for (int code = 0; code < 4; code++) begin
            int n;
            set_mode(1'b1, 1'b0, 2'(code));
            wait_tick();
            n = 1;
            while (!tick) begin @(negedge clk); n++; end
            chk($sformatf("R2 tick period code %0d", code), n, ratio(code));
            @(negedge clk);
            chk("R2 tick one cycle", tick, 0);
        end
    endtask

    task automatic t_stop_restart();
        int n, s0;
        set_mode(1'b1, 1'b0, 2'd0);
        set_mode(1'b0, 1'b0, 2'd0);
        s0 = seconds;
        repeat (3 * FR0) begin
            @(negedge clk);
            if (tick) chk("R2 no tick while stopped", 1, 0);
        end
        chk("R3 counters frozen", seconds, s0);
        set_mode(1'b1, 1'b0, 2'd0);
        n = 0;
        while (!tick) begin @(negedge clk); n++; end
        chk("R3 restart latency", n, FR0 - 1);
        @(negedge clk);
    endtask

    task automatic t_sec_min();
        load(10, 0, 5, 58, 7, 7, 1);
        wait_tick();
        chk("R5 sec 59", seconds, 59);
        wait_tick();
        chk("R5 sec wrap", seconds, 0); chk("R5 min carry", minutes, 6);
        chk("R5 hour held", hours, 10);
        load(10, 0, 59, 59, 7, 7, 1);
        wait_tick();
        chk("R5 min wrap", minutes, 0); chk("R5 hour carry", hours, 11);
    endtask

    task automatic t_24h();
        load(23, 0, 59, 59, 5, 3, 1);
        wait_tick();
        chk("R6 hour wrap", hours, 0); chk("R6 min", minutes, 0);
        chk("R6 day carry", day, 6);   chk("R6 month held", month, 3);
    endtask

    task automatic t_12h();
        set_mode(1'b0, 1'b1, 2'd0);
        load(11, 0, 59, 59, 10, 4, 1);
        wait_tick();
        chk("R7 11->12", hours, 12); chk("R7 pm set", pm, 1);
        chk("R7 noon no day", day, 10);
        load(12, 1, 59, 59, 10, 4, 1);
        wait_tick();
        chk("R7 12->1", hours, 1); chk("R7 pm kept", pm, 1);
        load(11, 1, 59, 59, 10, 4, 1);
        wait_tick();
        chk("R7 midnight hour", hours, 12); chk("R7 midnight am", pm, 0);
        chk("R7 midnight day", day, 11);
        set_mode(1'b1, 1'b0, 2'd0);
    endtask

    task automatic t_months();
        for (int mo = 1; mo <= 12; mo++) begin
            int dl = days_of(mo, 1);
            load(23, 0, 59, 59, dl - 1, mo, 1);
            wait_tick();
            chk($sformatf("R8 last day month %0d", mo), day, dl);
            load(23, 0, 59, 59, dl, mo, 1);
            wait_tick();
            chk($sformatf("R8 day wrap month %0d", mo), day, 1);
            chk($sformatf("R8 next month after %0d", mo), month, (mo % 12) + 1);
        end
    endtask

    task automatic t_feb();
        load(23, 0, 59, 59, 28, 2, 0);
        wait_tick();
        chk("R9 feb 29 in leap", day, 29); chk("R9 still feb", month, 2);
        load(23, 0, 59, 59, 29, 2, 0);
        wait_tick();
        chk("R9 mar 1 after 29", day, 1); chk("R9 march", month, 3);
        load(23, 0, 59, 59, 28, 2, 2);
        wait_tick();
        chk("R9 skip 29 phase 2", day, 1); chk("R9 march phase 2", month, 3);
    endtask

    task automatic t_leap_ctr();
        load(23, 0, 59, 59, 31, 12, 3);
        wait_tick();
        chk("R10 leap 3->0", leap_phase, 0); chk("R10 jan", month, 1);
        chk("R10 day 1", day, 1);
        load(23, 0, 59, 59, 31, 12, 0);
        wait_tick();
        chk("R10 leap 0->1", leap_phase, 1);
        load(23, 0, 59, 59, 30, 11, 2);
        wait_tick();
        chk("R10 no step in nov", leap_phase, 2);
    endtask

    task automatic t_write();
        load(4, 0, 3, 59, 9, 9, 1);
        set_mode(1'b0, 1'b0, 2'd0);
        wr(1, 30);
        chk("R11 write seconds", seconds, 30); chk("R11 minutes untouched", minutes, 3);
        wr(1, 59);
        wr(2, 59);
        chk("R11 no carry from write", hours, 4);
        wr(2, 3);
        set_mode(1'b1, 1'b0, 2'd0);
        while (!tick) @(negedge clk);
        wr(1, 20);
        chk("R11 write wins over tick", seconds, 20);
        chk("R11 no carry on write tick", minutes, 3);
        wait_tick();
        chk("R11 next tick advances", seconds, 21);
    endtask

    task automatic t_osc_fail();
        set_mode(1'b1, 1'b0, 2'd0);
        osc_fail = 1'b1; osc_ok = 1'b0;
        @(negedge clk);
        osc_fail = 1'b0;
        chk("R4 fail clears run", run, 0);
        set_mode(1'b1, 1'b0, 2'd0);
        chk("R4 run blocked after fail", run, 0);
        osc_ok = 1'b1;
        @(negedge clk);
        set_mode(1'b1, 1'b0, 2'd0);
        chk("R4 run after recovery", run, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_osc_gate();
        t_period();
        t_stop_restart();
        t_sec_min();
        t_24h();
        t_12h();
        t_months();
        t_feb();
        t_leap_ctr();
        t_write();
        t_osc_fail();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule